// File: doc/BRIEF.md
# Serial Controller Receive FIFO Register Bank

This block is the byte-wide register file of a classic PC-style serial controller. A host reaches it through a plain bus with a 3-bit address, write and read strobes, and 8-bit write data. Read data is a combinational function of the address. Any side effect of a read, such as a FIFO pop or the clearing of a flag, takes place at the clock edge that ends the read.

Received characters arrive on a byte-valid input with three error flags. They are queued in a 16-entry receive FIFO. A host write to the data address sends the byte out on a one-cycle transmit output. While the access bit (bit 7) of the line control register is set, a set of baud divisor registers replaces the data and interrupt-enable addresses. The divisor and prescaler drive ports for an external baud generator. Writes to the FIFO control address enable the FIFO, flush it and pick the receive trigger level.

Top module: `uart_rxfifo_regs`

## Requirements
- R1: After reset the registers read as follows: interrupt enable 0x00 at address 1, identification 0x01 at address 2, line control 0x00 at address 3, modem control 0x08 at address 4, line status 0x60 at address 5 and scratch 0x00 at address 7. The divisor reads 0x000C.
- R2: While line control bit 7 is 1, address 0 reads and writes the divisor low byte and address 1 the high byte. A write to address 5 loads the low nibble into the 4-bit prescaler. A write to address 0 then emits no transmit byte.
- R3: Received bytes leave the FIFO in arrival order, one byte per read of address 0 while line control bit 7 is 0. A read of an empty FIFO returns 0x00.
- R4: Line status bit 0 (data ready) is 1 exactly while the FIFO holds a byte. Line status bit 4 (break) clears when a pop empties the FIFO.
- R5: A byte that arrives while the FIFO already holds 16 entries and no pop occurs is dropped, and line status bit 1 (overrun) is set.
- R6: A byte received with its parity, framing or break flag (rx_flags bits 0, 1, 2) sets line status bit 2, 3 or 4 respectively, and also bit 7. A line status read returns the current value and then clears bits 1, 2, 3, 4 and 7.
- R7: A FIFO control write (address 2) equal to the stored value has no effect. Only bits 7, 6, 3 and 0 are stored. Any other write with bit 1 set flushes the receive FIFO.
- R8: A FIFO control write whose bit 0 differs from the stored enable bit flushes the receive FIFO even when bit 1 is clear.
- R9: While enabled, FIFO control bits 7:6 = 00, 01, 10, 11 select trigger levels of 1, 4, 8 and 14 bytes. rx_trigger is 1 when the FIFO holds at least that many bytes. The identification register reads 0xC1 while the FIFO is enabled and 0x01 otherwise. rx_trigger is 0 while the FIFO is disabled.
- R10: A modem control write keeps only its low 5 bits. The scratch register at address 7 returns the last value written.
- R11: With line control bit 7 at 0, a write to address 0 drives tx_valid high with tx_byte equal to the written byte for exactly the one cycle after the write. Line status then still reads 0x60 when no receive event is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; side effects apply at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| rx_flags | input | 3 | {break, framing, parity} error flags for the received byte |
| tx_valid | output | 1 | Transmit byte valid, one cycle per data write |
| tx_byte | output | 8 | Transmit byte |
| baud_div | output | 16 | Baud divisor |
| baud_pre | output | 4 | Baud prescaler |
| rx_trigger | output | 1 | FIFO fill has reached the trigger level |

## Verification
A FIFO pointer that goes wrong shows up at the first later pop as a byte out of order. It also shows up at once in line status bit 0 and on rx_trigger. A sticky error flag that fails to clear or to set is caught on the next line status read. A stored FIFO control value that is wrong shows up in the next write, as a flush that does or does not occur. Stimulus mixes random bursts of pushes and pops with directed runs to full, overrun, flush and every trigger level. Every pop is compared on the cycle it occurs.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
   localparam logic [2:0] A_DATA = 3'd0;
   localparam logic [2:0] A_IEN  = 3'd1;
   localparam logic [2:0] A_FCTL = 3'd2;
   localparam logic [2:0] A_LCTL = 3'd3;
   localparam logic [2:0] A_MCTL = 3'd4;
   localparam logic [2:0] A_LSTS = 3'd5;
   localparam logic [2:0] A_MSTS = 3'd6;
   localparam logic [2:0] A_SCR  = 3'd7;

   localparam logic [7:0] FCTL_KEEP = 8'hC9;

   typedef struct packed {
      logic brk;
      logic frm;
      logic par;
   } rx_err_t;

   function automatic int unsigned trig_level(input logic [1:0] code);
      case (code)
         2'b00:   return 1;
         2'b01:   return 4;
         2'b10:   return 8;
         default: return 14;
      endcase
   endfunction
endpackage

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         initial $error("uart_rx_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_pop  = pop && !empty && !flush;
   assign do_push = push && (!full || do_pop) && !flush;
   assign dout    = mem[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R5
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty); // R7
endmodule

// File: rtl/uart_lsr.sv
module uart_lsr
   import uart_rb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  rx_err_t    err,
   input  logic       overrun,
   input  logic       sts_read,
   input  logic       drained,
   input  logic       nonempty,
   output logic [7:0] lsr
);
   logic ovr_q, par_q, frm_q, brk_q, ferr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q  <= 1'b0;
         par_q  <= 1'b0;
         frm_q  <= 1'b0;
         brk_q  <= 1'b0;
         ferr_q <= 1'b0;
      end else begin
         ovr_q  <= (ovr_q  && !sts_read) || overrun;
         par_q  <= (par_q  && !sts_read) || (accept && err.par);
         frm_q  <= (frm_q  && !sts_read) || (accept && err.frm);
         brk_q  <= (brk_q  && !sts_read && !drained) || (accept && err.brk);
         ferr_q <= (ferr_q && !sts_read) || (accept && (err != '0));
      end
   end

   assign lsr = {ferr_q, 1'b1, 1'b1, brk_q, frm_q, par_q, ovr_q, nonempty};

   AST_LSR_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_read && !accept && !overrun) |=> (lsr[4:1] == 4'b0 && !lsr[7])); // R6
endmodule

// File: rtl/uart_rxfifo_regs.sv
module uart_rxfifo_regs
   import uart_rb_pkg::*;
#(
   parameter int          DEPTH     = 16,
   parameter logic [15:0] DIV_RESET = 16'h000C,
   parameter logic [4:0]  MCTL_RST  = 5'h08
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  bus_addr,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [7:0]  bus_wdata,
   output logic [7:0]  bus_rdata,
   input  logic        rx_valid,
   input  logic [7:0]  rx_byte,
   input  logic [2:0]  rx_flags,
   output logic        tx_valid,
   output logic [7:0]  tx_byte,
   output logic [15:0] baud_div,
   output logic [3:0]  baud_pre,
   output logic        rx_trigger
);
   localparam int CW = $clog2(DEPTH + 1);

   logic [7:0]  ier_q, lcr_q, scr_q, fcr_q;
   logic [4:0]  mcr_q;
   logic        dlab;
   logic [7:0]  lsr, iir, fifo_dout;
   logic [CW-1:0] count;
   logic        full, empty;
   logic        fifo_pop, fifo_flush, fctl_wr, accept, overrun, sts_read, drained;

   assign dlab = lcr_q[7];

   assign fctl_wr    = bus_wr && bus_addr == A_FCTL && bus_wdata != fcr_q;
   assign fifo_flush = fctl_wr && (bus_wdata[1] || (bus_wdata[0] != fcr_q[0]));
   assign fifo_pop   = bus_rd && !dlab && bus_addr == A_DATA;
   assign accept     = rx_valid && (!full || (fifo_pop && !empty)) && !fifo_flush;
   assign overrun    = rx_valid && full && !fifo_pop && !fifo_flush;
   assign sts_read   = bus_rd && !dlab && bus_addr == A_LSTS;
   assign drained    = fifo_pop && count == CW'(1) && !accept;

   uart_rx_fifo #(.DEPTH(DEPTH), .W(8)) i_fifo (
      .clk(clk), .rst_n(rst_n), .flush(fifo_flush), .push(rx_valid), .din(rx_byte),
      .pop(fifo_pop), .dout(fifo_dout), .count(count), .full(full), .empty(empty)
   );

   uart_lsr i_lsr (
      .clk(clk), .rst_n(rst_n), .accept(accept), .err(rx_err_t'(rx_flags)),
      .overrun(overrun), .sts_read(sts_read), .drained(drained),
      .nonempty(!empty), .lsr(lsr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ier_q    <= '0;
         lcr_q    <= '0;
         scr_q    <= '0;
         fcr_q    <= '0;
         mcr_q    <= MCTL_RST;
         baud_div <= DIV_RESET;
         baud_pre <= '0;
         tx_valid <= 1'b0;
         tx_byte  <= '0;
      end else begin
         tx_valid <= 1'b0;
         if (bus_wr) begin
            case (bus_addr)
               A_DATA: if (dlab) baud_div[7:0] <= bus_wdata;
                       else begin
                          tx_valid <= 1'b1;
                          tx_byte  <= bus_wdata;
                       end
               A_IEN:  if (dlab) baud_div[15:8] <= bus_wdata;
                       else ier_q <= bus_wdata;
               A_FCTL: if (fctl_wr) fcr_q <= bus_wdata & FCTL_KEEP;
               A_LCTL: lcr_q <= bus_wdata;
               A_MCTL: mcr_q <= bus_wdata[4:0];
               A_LSTS: if (dlab) baud_pre <= bus_wdata[3:0];
               A_SCR:  scr_q <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   assign iir        = {{2{fcr_q[0]}}, 6'b000001};
   assign rx_trigger = fcr_q[0] && (int'(count) >= int'(trig_level(fcr_q[7:6])));

   always_comb begin
      case (bus_addr)
         A_DATA:  bus_rdata = dlab ? baud_div[7:0] : (empty ? 8'h00 : fifo_dout);
         A_IEN:   bus_rdata = dlab ? baud_div[15:8] : ier_q;
         A_FCTL:  bus_rdata = iir;
         A_LCTL:  bus_rdata = lcr_q;
         A_MCTL:  bus_rdata = {3'b000, mcr_q};
         A_LSTS:  bus_rdata = lsr;
         A_MSTS:  bus_rdata = 8'h00;
         default: bus_rdata = scr_q;
      endcase
   end

   AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && full && !bus_rd && !bus_wr) |=> lsr[1]); // R5
   AST_TX_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_DATA && !dlab) |=> (tx_valid && tx_byte == $past(bus_wdata))); // R11
   AST_DLAB_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_DATA && dlab) |=> !tx_valid); // R2
   AST_DR_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop && !lsr[0]) |-> bus_rdata == 8'h00); // R3
endmodule

// File: tb/test_uart_rxfifo_regs.sv
module test_uart_rxfifo_regs;
   localparam time CLK = 4ns;

   logic clk = 0, rst_n = 0;
   logic [2:0] bus_addr = 0;
   logic bus_wr = 0, bus_rd = 0;
   logic [7:0] bus_wdata = 0, bus_rdata;
   logic rx_valid = 0;
   logic [7:0] rx_byte = 0;
   logic [2:0] rx_flags = 0;
   logic tx_valid;
   logic [7:0] tx_byte;
   logic [15:0] baud_div;
   logic [3:0] baud_pre;
   logic rx_trigger;

   int vectors = 0, miscompares = 0;
   bit done = 0;
   logic [7:0] q[$];
   bit m_ovr = 0;

   always #(CLK/2) clk = ~clk;

   uart_rxfifo_regs i_uart_rxfifo_regs (.*);

   function automatic int lvl(input logic [1:0] c);
      return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(posedge clk); @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1; #1;
      d = bus_rdata;
      @(posedge clk); @(negedge clk);
      bus_rd = 0;
   endtask

   task automatic push(input logic [7:0] b, input logic [2:0] f);
      rx_valid = 1; rx_byte = b; rx_flags = f;
      @(posedge clk); @(negedge clk);
      rx_valid = 0; rx_flags = 0;
      if (q.size() < 16) q.push_back(b); else m_ovr = 1;
   endtask

   task automatic pop_chk(input string req);
      logic [7:0] d;
      logic [7:0] e;
      e = (q.size() > 0) ? q.pop_front() : 8'h00;
      rd(3'd0, d);
      check(req, d, e);
   endtask

   initial begin
      #(CLK * 200000);
      miscompares++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      logic [7:0] d;
      void'($urandom(1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset values
      rd(3'd1, d); check("R1 ien", d, 8'h00);
      rd(3'd2, d); check("R1 iir", d, 8'h01);
      rd(3'd3, d); check("R1 lctl", d, 8'h00);
      rd(3'd4, d); check("R1 mctl", d, 8'h08);
      rd(3'd5, d); check("R1 lsts", d, 8'h60);
      rd(3'd7, d); check("R1 scr", d, 8'h00);
      check("R1 baud_div", baud_div, 16'h000C);
      wr(3'd3, 8'h80);
      rd(3'd0, d); check("R1 div lo", d, 8'h0C);
      rd(3'd1, d); check("R1 div hi", d, 8'h00);
      // R2 banking
      wr(3'd0, 8'h34);
      check("R2 no tx", tx_valid, 0);
      wr(3'd1, 8'h12);
      wr(3'd5, 8'hA7);
      rd(3'd0, d); check("R2 div lo", d, 8'h34);
      rd(3'd1, d); check("R2 div hi", d, 8'h12);
      check("R2 baud_div", baud_div, 16'h1234);
      check("R2 baud_pre", baud_pre, 4'h7);
      wr(3'd3, 8'h03);
      rd(3'd1, d); check("R2 ien unbanked", d, 8'h00);
      // R10
      wr(3'd7, 8'h5A); rd(3'd7, d); check("R10 scr", d, 8'h5A);
      wr(3'd4, 8'hFF); rd(3'd4, d); check("R10 mctl", d, 8'h1F);
      // R11
      wr(3'd0, 8'h3C);
      check("R11 tx_valid", tx_valid, 1);
      check("R11 tx_byte", tx_byte, 8'h3C);
      @(posedge clk); @(negedge clk);
      check("R11 tx pulse", tx_valid, 0);
      rd(3'd5, d); check("R11 lsts", d, 8'h60);
      // R3 empty read, order
      pop_chk("R3 empty");
      for (int i = 0; i < 3; i++) push(8'($urandom), 3'b000);
      rd(3'd5, d); check("R4 dr set", d[0], 1);
      for (int i = 0; i < 3; i++) pop_chk("R3 order");
      rd(3'd5, d); check("R4 dr clear", d[0], 0);
      // R5 overrun
      for (int i = 0; i < 17; i++) push(8'(i * 7 + 1), 3'b000);
      rd(3'd5, d); check("R5 overrun", d, 8'h63);
      rd(3'd5, d); check("R6 ovr cleared", d, 8'h61);
      m_ovr = 0;
      for (int i = 0; i < 16; i++) pop_chk("R5 kept");
      // R6 error flags
      push(8'h11, 3'b001); push(8'h22, 3'b010);
      rd(3'd5, d); check("R6 par frm", d, 8'hED);
      rd(3'd5, d); check("R6 cleared", d, 8'h61);
      pop_chk("R6 data"); pop_chk("R6 data");
      push(8'h33, 3'b100);
      rd(3'd0, d); check("R3 brk byte", d, q.pop_front());
      rd(3'd5, d); check("R4 brk cleared on drain", d, 8'hE0);
      rd(3'd5, d); check("R6 ferr cleared", d, 8'h60);
      // R8 enable toggle flush
      push(8'h44, 3'b000); push(8'h55, 3'b000);
      wr(3'd2, 8'h01); q.delete();
      rd(3'd5, d); check("R8 flush on enable", d[0], 0);
      rd(3'd2, d); check("R9 iir enabled", d, 8'hC1);
      // R9 trigger 1
      check("R9 lvl1 empty", rx_trigger, 0);
      push(8'h01, 0); check("R9 lvl1 hit", rx_trigger, 1);
      pop_chk("R9 pop");
      // R9 level 4, no flush
      wr(3'd2, 8'h41);
      for (int i = 0; i < 3; i++) push(8'(i + 8'h80), 0);
      check("R9 lvl4 below", rx_trigger, 0);
      push(8'h83, 0); check("R9 lvl4 hit", rx_trigger, 1);
      // R7 equal write no effect
      wr(3'd2, 8'h41);
      check("R7 equal write", rx_trigger, 1);
      pop_chk("R7 kept");
      wr(3'd2, 8'h43); q.delete();
      rd(3'd5, d); check("R7 flush bit", d[0], 0);
      wr(3'd2, 8'h81);
      for (int i = 0; i < 7; i++) push(8'(i), 0);
      check("R9 lvl8 below", rx_trigger, 0);
      push(8'h07, 0); check("R9 lvl8 hit", rx_trigger, 1);
      wr(3'd2, 8'hC3); q.delete();
      for (int i = 0; i < 13; i++) push(8'(i), 0);
      check("R9 lvl14 below", rx_trigger, 0);
      push(8'h0D, 0); check("R9 lvl14 hit", rx_trigger, 1);
      wr(3'd2, 8'h00); q.delete();
      rd(3'd5, d); check("R8 flush on disable", d[0], 0);
      rd(3'd2, d); check("R9 iir disabled", d, 8'h01);
      push(8'h99, 0); check("R9 no trig disabled", rx_trigger, 0);
      // random mix
      for (int i = 0; i < 400; i++) begin
         int op = $urandom_range(0, 9);
         if (op < 5) push(8'($urandom), 3'b000);
         else if (op < 9) pop_chk("R3 random");
         else begin
            rd(3'd5, d);
            check("R5 random lsts", d, {6'b011000, m_ovr, q.size() > 0});
            m_ovr = 0;
         end
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule